// File: doc/BRIEF.md
# Dual-Port GPIO Interrupt Controller

This block holds two 8-bit general-purpose I/O ports. Lines 0 to 7 belong to port A and lines 8 to 15 to port B. Each line can be set up as an input or an output, and each line can raise an interrupt. A simple register bus reaches all state: address, write data, write enable, read enable and combinational read data. Pads stay outside the block. Each pin is seen as an input bit, an output bit and an output-enable bit.

Every line has three interrupt configuration bits:
- an enable bit;
- a kind bit that picks level or edge;
- a sense bit that picks low/falling or high/rising.

A level line reports its pin state live. An edge line stores the event until software clears it with a write-one acknowledge, or until the line is disabled. Pin inputs pass through a two-flop synchronizer. The pending bits of all 16 lines are ORed into one interrupt output.

Top module: `gpio_irq_ports`

## Requirements
- R1: After reset, every register reads 0, pin_out and pin_oe are 0 and irq is 0.
- R2: A write to 0x00 (port A) or 0x04 (port B) loads that port's output data, which appears on pin_out one clock later. A write to 0x10 (A) or 0x14 (B) loads the direction register, which appears on pin_oe; bit value 1 makes the line an output.
- R3: A read of 0x00/0x04 returns, per line, the output data bit when the direction bit is 1, else the synchronized pin input. A pin change becomes visible there after two rising clock edges.
- R4: The interrupt configuration registers read back what was written. Port A has kind at 0x90, sense at 0x94 and enable at 0x9C; port B has the same registers at 0xB0, 0xB4 and 0xBC.
- R5: A line with kind bit 0 is level-triggered. Its status bit (port A 0xA0, port B 0xC0) is 1 exactly while it is enabled and its synchronized pin equals its sense bit. Nothing is latched, and acknowledge writes do not change it.
- R6: A line with kind bit 1 is edge-triggered. A rising edge (sense 1) or falling edge (sense 0) seen while enabled sets a latched status bit. The bit is readable after the third rising clock edge that follows the pin change, and it stays set after the pin returns.
- R7: Writing 1 to bit n of the acknowledge register (A 0x98, B 0xB8) clears line n's latched edge. Bits written as 0 leave their lines unchanged.
- R8: A line whose enable bit is 0 reports status 0. Clearing the enable bit discards any latched edge. Edges that occur while a line is disabled are never recorded.
- R9: irq is 1 exactly when any status bit of either port is 1.
- R10: Writes to status registers or unmapped addresses change nothing. Reads of unmapped addresses return 0, and bus_rdata is 0 whenever bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, captured at the clock edge |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 16 | Pin levels, bit n is line n |
| pin_out | output | 16 | Output data to the pads |
| pin_oe | output | 16 | Output enables to the pads |
| irq | output | 1 | Combined interrupt |

## Verification
Random rounds set random sense, enable and pin patterns on level-configured lines. They also set random direction and output data. This separates a correct polarity compare and enable gating from a swapped or ungated one, and shows whether each line's read level comes from the right source. Directed edge sequences use one rising-sense line on port A and one falling-sense line on port B. Each sequence samples status one cycle before and on the cycle the latch must appear. It then returns the pin to its old level, acknowledges with a mask that has every bit except the pending one, and then acknowledges the pending bit. This separates latching from level following and write-one clearing from write-value clearing. Toggling pins while a line is disabled, then re-enabling it, shows whether stale edges leak through. Writes to the status register and to unmapped addresses check that nothing changes.

// File: rtl/gpio_irq_ports.sv
module gpio_irq_ports #(
  parameter int W      = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [W-1:0]      bus_rdata,
  input  logic [2*W-1:0]    pin_in,
  output logic [2*W-1:0]    pin_out,
  output logic [2*W-1:0]    pin_oe,
  output logic              irq
);
  localparam int N = 2 * W;
  localparam logic [ADDR_W-1:0] OFS_DAT_A  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_DAT_B  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_DIR_A  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_DIR_B  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] STEP_B     = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_KIND_A = ADDR_W'('h90);
  localparam logic [ADDR_W-1:0] OFS_SENS_A = ADDR_W'('h94);
  localparam logic [ADDR_W-1:0] OFS_ACK_A  = ADDR_W'('h98);
  localparam logic [ADDR_W-1:0] OFS_EN_A   = ADDR_W'('h9C);
  localparam logic [ADDR_W-1:0] OFS_STAT_A = ADDR_W'('hA0);
  localparam logic [ADDR_W-1:0] OFS_KIND_B = OFS_KIND_A + STEP_B;
  localparam logic [ADDR_W-1:0] OFS_SENS_B = OFS_SENS_A + STEP_B;
  localparam logic [ADDR_W-1:0] OFS_ACK_B  = OFS_ACK_A + STEP_B;
  localparam logic [ADDR_W-1:0] OFS_EN_B   = OFS_EN_A + STEP_B;
  localparam logic [ADDR_W-1:0] OFS_STAT_B = OFS_STAT_A + STEP_B;

  logic [N-1:0] out_r, dir_r, kind_r, sens_r, en_r, latch_r;
  logic [N-1:0] sync1, sync2, prev;
  logic [N-1:0] ack_mask, edge_hit, lvl_hit, status, line_lvl, latch_nxt;

  assign ack_mask[W-1:0] = (bus_we && bus_addr == OFS_ACK_A) ? bus_wdata : '0;
  assign ack_mask[N-1:W] = (bus_we && bus_addr == OFS_ACK_B) ? bus_wdata : '0;

  assign edge_hit  = (sens_r & sync2 & ~prev) | (~sens_r & ~sync2 & prev);
  assign lvl_hit   = ~(sync2 ^ sens_r);
  assign latch_nxt = en_r & kind_r & ((latch_r & ~ack_mask) | edge_hit);
  assign status    = en_r & ((kind_r & latch_r) | (~kind_r & lvl_hit));
  assign line_lvl  = (dir_r & out_r) | (~dir_r & sync2);

  assign pin_out = out_r;
  assign pin_oe  = dir_r;
  assign irq     = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r   <= '0;
      dir_r   <= '0;
      kind_r  <= '0;
      sens_r  <= '0;
      en_r    <= '0;
      latch_r <= '0;
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
    end else begin
      sync1   <= pin_in;
      sync2   <= sync1;
      prev    <= sync2;
      latch_r <= latch_nxt;
      if (bus_we) begin
        case (bus_addr)
          OFS_DAT_A:  out_r[W-1:0]  <= bus_wdata;
          OFS_DAT_B:  out_r[N-1:W]  <= bus_wdata;
          OFS_DIR_A:  dir_r[W-1:0]  <= bus_wdata;
          OFS_DIR_B:  dir_r[N-1:W]  <= bus_wdata;
          OFS_KIND_A: kind_r[W-1:0] <= bus_wdata;
          OFS_KIND_B: kind_r[N-1:W] <= bus_wdata;
          OFS_SENS_A: sens_r[W-1:0] <= bus_wdata;
          OFS_SENS_B: sens_r[N-1:W] <= bus_wdata;
          OFS_EN_A:   en_r[W-1:0]   <= bus_wdata;
          OFS_EN_B:   en_r[N-1:W]   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        OFS_DAT_A:  bus_rdata = line_lvl[W-1:0];
        OFS_DAT_B:  bus_rdata = line_lvl[N-1:W];
        OFS_DIR_A:  bus_rdata = dir_r[W-1:0];
        OFS_DIR_B:  bus_rdata = dir_r[N-1:W];
        OFS_KIND_A: bus_rdata = kind_r[W-1:0];
        OFS_KIND_B: bus_rdata = kind_r[N-1:W];
        OFS_SENS_A: bus_rdata = sens_r[W-1:0];
        OFS_SENS_B: bus_rdata = sens_r[N-1:W];
        OFS_EN_A:   bus_rdata = en_r[W-1:0];
        OFS_EN_B:   bus_rdata = en_r[N-1:W];
        OFS_STAT_A: bus_rdata = status[W-1:0];
        OFS_STAT_B: bus_rdata = status[N-1:W];
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

module gpio_irq_ports_chk #(
  parameter int W      = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [2*W-1:0]    pin_out,
  input logic [2*W-1:0]    pin_oe,
  input logic              irq,
  input logic [2*W-1:0]    en,
  input logic [2*W-1:0]    latch,
  input logic [2*W-1:0]    status
);
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h10)) |=> pin_oe[W-1:0] == $past(bus_wdata));

  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h04)) |=> pin_out[2*W-1:W] == $past(bus_wdata));

  assert_status_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~en) == '0);

  assert_disable_drops_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> latch == '0);

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en != '0);
endmodule

bind gpio_irq_ports gpio_irq_ports_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .en(en_r), .latch(latch_r), .status(status)
);

// File: tb/tb_gpio_irq_ports.sv
module tb_gpio_irq_ports;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0;
  logic        bus_we = 0, bus_re = 0;
  logic [7:0]  bus_rdata;
  logic [15:0] pins = 0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ports dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [15:0] exp_level(logic [15:0] p, logic [15:0] s, logic [15:0] e);
    return e & ~(p ^ s);
  endfunction

  function automatic logic [15:0] exp_read(logic [15:0] d, logic [15:0] o, logic [15:0] p);
    return (d & o) | (~d & p);
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    bus_re = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, {8'h0, d}, {8'h0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, rb;
    void'($urandom(32'h5EED1234));
    tick(3);
    rst_n = 1;
    tick(1);

    // R1 reset state
    foreach (dut.out_r[i]) ;
    rd_chk("R1 data A", 8'h00, 8'h00);
    rd_chk("R1 dir B", 8'h14, 8'h00);
    rd_chk("R1 kind A", 8'h90, 8'h00);
    rd_chk("R1 en B", 8'hBC, 8'h00);
    rd_chk("R1 status A", 8'hA0, 8'h00);
    check("R1 pin_oe", pin_oe, 16'h0);
    check("R1 pin_out", pin_out, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);

    // R2 output path
    wr(8'h00, 8'hA5); wr(8'h04, 8'h3C);
    wr(8'h10, 8'h0F); wr(8'h14, 8'hF0);
    check("R2 pin_out", pin_out, 16'h3CA5);
    check("R2 pin_oe", pin_oe, 16'hF00F);

    // R4 config readback
    wr(8'h94, 8'h5A); wr(8'hB4, 8'hC3); wr(8'hB0, 8'h81);
    rd_chk("R4 sense A", 8'h94, 8'h5A);
    rd_chk("R4 sense B", 8'hB4, 8'hC3);
    rd_chk("R4 kind B", 8'hB0, 8'h81);
    wr(8'hB0, 8'h00);

    // R3, R5, R9 random level rounds
    for (int k = 0; k < 40; k++) begin
      logic [15:0] s, e, p, d, o, lv;
      s = 16'($urandom); e = 16'($urandom); p = 16'($urandom);
      d = 16'($urandom); o = 16'($urandom);
      wr(8'h94, s[7:0]); wr(8'hB4, s[15:8]);
      wr(8'h9C, e[7:0]); wr(8'hBC, e[15:8]);
      wr(8'h10, d[7:0]); wr(8'h14, d[15:8]);
      wr(8'h00, o[7:0]); wr(8'h04, o[15:8]);
      pins = p;
      tick(2);
      lv = exp_level(p, s, e);
      rd(8'hA0, ra); rd(8'hC0, rb);
      check("R5 level status", {rb, ra}, lv);
      check("R9 irq level", {15'h0, irq}, {15'h0, |lv});
      rd(8'h00, ra); rd(8'h04, rb);
      check("R3 data read", {rb, ra}, exp_read(d, o, p));
    end

    // R3 two-edge visibility
    wr(8'h10, 8'h00);
    pins[0] = ~pins[0];
    tick(1);
    rd(8'h00, ra);
    check("R3 before sync", {15'h0, ra[0]}, {15'h0, ~pins[0]});
    tick(1);
    rd(8'h00, ra);
    check("R3 after sync", {15'h0, ra[0]}, {15'h0, pins[0]});

    // R5 ack has no effect on level lines
    wr(8'h90, 8'h00); wr(8'h94, 8'h02); wr(8'h9C, 8'h02);
    pins[1] = 1; tick(2);
    wr(8'h98, 8'hFF);
    rd_chk("R5 level ignores ack", 8'hA0, 8'h02);
    pins[1] = 0; tick(2);
    rd_chk("R5 level not latched", 8'hA0, 8'h00);

    // R6 edge: line 3 rising on A, line 10 falling on B
    wr(8'h9C, 8'h00); wr(8'hBC, 8'h00);
    pins = 16'h0400;
    wr(8'h90, 8'h08); wr(8'h94, 8'h08);
    wr(8'hB0, 8'h04); wr(8'hB4, 8'h00);
    tick(3);
    wr(8'h9C, 8'h08); wr(8'hBC, 8'h04);
    rd_chk("R6 idle", 8'hA0, 8'h00);
    pins[3] = 1;
    tick(2);
    rd_chk("R6 not yet latched", 8'hA0, 8'h00);
    tick(1);
    rd_chk("R6 rising latched", 8'hA0, 8'h08);
    check("R9 irq edge", {15'h0, irq}, 16'h1);
    pins[3] = 0; tick(3);
    rd_chk("R6 held after pin returns", 8'hA0, 8'h08);
    pins[10] = 0; tick(3);
    rd_chk("R6 falling latched", 8'hC0, 8'h04);

    // R7 write-one acknowledge
    wr(8'h98, 8'hF7);
    rd_chk("R7 zero bits keep", 8'hA0, 8'h08);
    wr(8'h98, 8'h08);
    rd_chk("R7 one clears", 8'hA0, 8'h00);
    check("R9 irq from B", {15'h0, irq}, 16'h1);

    // R10 status write and unmapped ignored
    wr(8'hC0, 8'h00); wr(8'h50, 8'hFF);
    rd_chk("R10 status write ignored", 8'hC0, 8'h04);
    rd_chk("R10 unmapped read", 8'h50, 8'h00);
    bus_addr = 8'hC0; #1;
    check("R10 rdata idle", {8'h0, bus_rdata}, 16'h0);

    // R8 disable drops latch, disabled edges ignored
    wr(8'hBC, 8'h00);
    rd_chk("R8 disabled status", 8'hC0, 8'h00);
    check("R9 irq cleared", {15'h0, irq}, 16'h0);
    wr(8'hBC, 8'h04);
    rd_chk("R8 latch discarded", 8'hC0, 8'h00);
    wr(8'h9C, 8'h00);
    pins[3] = 1; tick(4); pins[3] = 0; tick(4);
    wr(8'h9C, 8'h08);
    tick(3);
    rd_chk("R8 disabled edge ignored", 8'hA0, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule